// File: doc/BRIEF.md
# Link Reinitialization Controller

This block decides when the transport and link layers of a serial link controller are wiped and brought back to their starting state. It does not touch the transceiver, the PHY logic, the timing-reference capture logic or the control/status register file. A reinitialization can be started in two ways. Software can write a self-clearing request bit. The hardware can also start one when a latched error of an enabled type is present. While a run is active the block drives a synchronous clear to the two layers. A busy flag stays set until the hardware retires it.

Software reaches the block through a small register port with a single-cycle write and a combinational read. Error events from the transmit and receive paths are latched per bit and held until software clears them by writing ones. An enable mask for each direction selects which latched errors may start an automatic run. A condition that stays present starts only one run. The enable masks and the error status are registers outside the cleared layers, so a run leaves them unchanged.

Top module: `link_reinit_ctrl`

## Requirements
- R1: After reset, layer_clr and reinit_busy are 0 and every register reads 0.
- R2: Writing 1 to bit 0 of the control register (address 0x54) while idle raises layer_clr on the next cycle. During the run, the control register reads bit 0 = 1 (request) and bit 1 = 1 (busy).
- R3: layer_clr stays high for exactly CLEAR_CYCLES consecutive cycles. reinit_busy is also high in the cycle after layer_clr falls and is low in the cycle after that.
- R4: When a run started by software completes, the hardware clears both bit 0 and bit 1 of the control register.
- R5: A write to the control register while a run is active is ignored. The run is neither restarted nor lengthened.
- R6: An event on tx_err_evt[i] or rx_err_evt[i] sets bit i of the transmit status register (0x68) or the receive status register (0x6C). The bit stays set until software writes 1 to it. If an event and that clearing write fall in the same cycle, the bit stays set.
- R7: An automatic run starts one cycle after the AND of status with the enable mask becomes nonzero. The masks sit at 0x60 (transmit) and 0x64 (receive), and bit i enables error i. Latched errors that are masked off start nothing.
- R8: A run started only by errors leaves control bit 0 at 0, so the control register reads 2 during the run. A condition that stays present after the run completes starts no further run.
- R9: If a software request and a rising error condition arrive on the same edge, exactly one run of CLEAR_CYCLES cycles occurs. Bit 0 of the control register is set during that run and cleared at its end.
- R10: Writing the control register with bit 0 = 0 starts nothing, whatever the other bits hold.
- R11: A run does not alter the enable masks or the error status registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| tx_err_evt | input | NUM_TX_ERR | Transmit error event pulses, one bit per type |
| rx_err_evt | input | NUM_RX_ERR | Receive error event pulses, one bit per type |
| layer_clr | output | 1 | Synchronous clear to transport and link layers |
| reinit_busy | output | 1 | Reinitialization in progress |

## Verification
Two starts can land on the same clock edge: a software request and a rising error condition. To provoke this, the bench pulses an enabled error one cycle before the control write, so that the status bit latches first and the rising condition meets the write on the same edge. The bench passes if it sees exactly one clear window of CLEAR_CYCLES cycles, reads 3 from the control register during it, sees the request bit cleared at the end and sees no second window afterwards. A second collision is also swept: an error event arriving in the same cycle as a write-one-to-clear of its own status bit.

// File: rtl/lrc_pkg.sv
// Shared definitions for the link reinitialization controller.
// Assumes an 8-bit byte address space for the register port.
package lrc_pkg;
    localparam int REG_ADDR_W = 8;

    localparam logic [REG_ADDR_W-1:0] ADDR_CTRL  = 8'h54;
    localparam logic [REG_ADDR_W-1:0] ADDR_TX_EN = 8'h60;
    localparam logic [REG_ADDR_W-1:0] ADDR_RX_EN = 8'h64;
    localparam logic [REG_ADDR_W-1:0] ADDR_TX_ST = 8'h68;
    localparam logic [REG_ADDR_W-1:0] ADDR_RX_ST = 8'h6C;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_DONE  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/lrc_err_latch.sv
// Per-direction error latch: sticky status bits with write-one-to-clear
// and an enable mask register. 'hit' is high when any enabled bit is latched.
// Assumes events are single-cycle or level pulses sampled on clk.
module lrc_err_latch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         st_wr,
    input  logic [W-1:0] st_w1c,
    input  logic         en_wr,
    input  logic [W-1:0] en_data,
    output logic [W-1:0] stat,
    output logic [W-1:0] en,
    output logic         hit
);
    // Enable mask register, written whole by software.
    always_ff @(posedge clk) begin
        if (!rst_n)     en <= '0;
        else if (en_wr) en <= en_data;
    end

    // One sticky bit per error type; an event beats a clear in the same cycle.
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)                   stat[i] <= 1'b0;
            else if (evt[i])              stat[i] <= 1'b1;
            else if (st_wr && st_w1c[i])  stat[i] <= 1'b0;
        end
    end

    assign hit = |(stat & en);

    // R6
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((stat & $past(evt)) == $past(evt)));

    // R6
    sticky_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((stat & ~$past(stat) & ~$past(evt)) == '0));
endmodule

// File: rtl/lrc_seq.sv
// Reinitialization sequencer: idle -> clear window of CLEAR_CYCLES cycles ->
// one tail cycle with busy still set -> idle. Starts on a software request
// or on a rising automatic condition; both are ignored while a run is active.
module lrc_seq #(
    parameter int CLEAR_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic man_req,
    input  logic auto_cond,
    output logic busy,
    output logic clr,
    output logic reinit_bit
);
    import lrc_pkg::*;

    localparam int CW = $clog2(CLEAR_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CLEAR_CYCLES - 1);

    seq_state_t    state;
    logic [CW-1:0] cnt;
    logic          auto_q;
    logic          auto_rise;

    assign auto_rise = auto_cond & ~auto_q;

    // Edge memory for the automatic condition.
    always_ff @(posedge clk) begin
        if (!rst_n) auto_q <= 1'b0;
        else        auto_q <= auto_cond;
    end

    // Run state, clear-window counter and the self-clearing request bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            reinit_bit <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (man_req || auto_rise) begin
                        state <= ST_CLEAR;
                        cnt   <= '0;
                    end
                    if (man_req) reinit_bit <= 1'b1;
                end
                ST_CLEAR: begin
                    if (cnt == LAST) state <= ST_DONE;
                    else             cnt   <= cnt + CW'(1);
                end
                ST_DONE: begin
                    state      <= ST_IDLE;
                    reinit_bit <= 1'b0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);
    assign clr  = (state == ST_CLEAR);

    // R3
    clr_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> busy);

    // R3
    busy_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clr) |=> !busy);

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R5
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && clr && $past(clr)) |-> (cnt == $past(cnt) + CW'(1)));

    // R4
    bit_retired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !reinit_bit);

    // R8
    auto_no_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(busy) && !$past(man_req)) |-> !reinit_bit);
endmodule

// File: rtl/link_reinit_ctrl.sv
// Link reinitialization controller top: register decode, two error latches
// and the sequencer. layer_clr is meant for transport/link-layer logic only;
// the registers here are never cleared by a run.
module link_reinit_ctrl #(
    parameter int DATA_W       = 32,
    parameter int NUM_TX_ERR   = 4,
    parameter int NUM_RX_ERR   = 4,
    parameter int CLEAR_CYCLES = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [7:0]            reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [NUM_TX_ERR-1:0] tx_err_evt,
    input  logic [NUM_RX_ERR-1:0] rx_err_evt,
    output logic                  layer_clr,
    output logic                  reinit_busy
);
    import lrc_pkg::*;

    logic [NUM_TX_ERR-1:0] tx_stat, tx_en;
    logic [NUM_RX_ERR-1:0] rx_stat, rx_en;
    logic                  tx_hit, rx_hit;
    logic                  man_req;
    logic                  req_bit;

    // Software request: write to the control register with bit 0 set.
    assign man_req = reg_wr && (reg_addr == ADDR_CTRL) && reg_wdata[0];

    lrc_err_latch #(.W(NUM_TX_ERR)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (tx_err_evt),
        .st_wr   (reg_wr && (reg_addr == ADDR_TX_ST)),
        .st_w1c  (reg_wdata[NUM_TX_ERR-1:0]),
        .en_wr   (reg_wr && (reg_addr == ADDR_TX_EN)),
        .en_data (reg_wdata[NUM_TX_ERR-1:0]),
        .stat    (tx_stat),
        .en      (tx_en),
        .hit     (tx_hit)
    );

    lrc_err_latch #(.W(NUM_RX_ERR)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (rx_err_evt),
        .st_wr   (reg_wr && (reg_addr == ADDR_RX_ST)),
        .st_w1c  (reg_wdata[NUM_RX_ERR-1:0]),
        .en_wr   (reg_wr && (reg_addr == ADDR_RX_EN)),
        .en_data (reg_wdata[NUM_RX_ERR-1:0]),
        .stat    (rx_stat),
        .en      (rx_en),
        .hit     (rx_hit)
    );

    lrc_seq #(.CLEAR_CYCLES(CLEAR_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .man_req    (man_req),
        .auto_cond  (tx_hit | rx_hit),
        .busy       (reinit_busy),
        .clr        (layer_clr),
        .reinit_bit (req_bit)
    );

    // Combinational read mux; unmapped addresses read zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL:  begin
                reg_rdata[0] = req_bit;
                reg_rdata[1] = reinit_busy;
            end
            ADDR_TX_EN: reg_rdata[NUM_TX_ERR-1:0] = tx_en;
            ADDR_RX_EN: reg_rdata[NUM_RX_ERR-1:0] = rx_en;
            ADDR_TX_ST: reg_rdata[NUM_TX_ERR-1:0] = tx_stat;
            ADDR_RX_ST: reg_rdata[NUM_RX_ERR-1:0] = rx_stat;
            default:    reg_rdata = '0;
        endcase
    end

    // R7
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(reinit_busy) && !$past(man_req)
         && !$past(tx_hit | rx_hit)) |-> !layer_clr);

    // R11
    mask_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && layer_clr && !$past(reg_wr)) |-> ($stable(tx_en) && $stable(rx_en)));
endmodule

// File: tb/tb_link_reinit_ctrl.sv
`timescale 1ns/100ps
module tb_link_reinit_ctrl;
    localparam int DW = 32;
    localparam int NT = 3;
    localparam int NR = 3;
    localparam int N  = 5;

    localparam logic [7:0] A_CTRL = 8'h54, A_TXE = 8'h60, A_RXE = 8'h64,
                           A_TXS = 8'h68, A_RXS = 8'h6C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [NT-1:0] tx_err_evt = '0;
    logic [NR-1:0] rx_err_evt = '0;
    logic          layer_clr, reinit_busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    link_reinit_ctrl #(.DATA_W(DW), .NUM_TX_ERR(NT), .NUM_RX_ERR(NR),
                       .CLEAR_CYCLES(N)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_err_evt(tx_err_evt),
        .rx_err_evt(rx_err_evt), .layer_clr(layer_clr), .reinit_busy(reinit_busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the write edge.
    task automatic wr(input logic [7:0] a, input int d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        reg_addr = a;
        #0.5;
        v = int'(reg_rdata);
    endtask

    // Counts clear cycles from the current negedge, then checks the busy tail.
    task automatic run_len(input string req, output int n);
        n = 0;
        while (layer_clr && n < 64) begin n++; @(negedge clk); end
        chk(reinit_busy == 1'b1, "R3 tail busy", int'(reinit_busy), 1);
        @(negedge clk);
        chk(reinit_busy == 1'b0, "R3 busy drop", int'(reinit_busy), 0);
        chk(n == N, req, n, N);
    endtask

    task automatic quiet(input int cyc, input string req);
        bit seen = 1'b0;
        for (int k = 0; k < cyc; k++) begin
            @(negedge clk);
            if (layer_clr) seen = 1'b1;
        end
        chk(!seen, req, int'(seen), 0);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int v, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!layer_clr && !reinit_busy, "R1 outputs", int'(layer_clr) + int'(reinit_busy), 0);
        rd(A_CTRL, v); chk(v == 0, "R1 ctrl", v, 0);
        rd(A_TXE, v);  chk(v == 0, "R1 txen", v, 0);
        rd(A_RXS, v);  chk(v == 0, "R1 rxst", v, 0);

        // R10 writes with bit 0 clear do nothing
        wr(A_CTRL, 0);
        wr(A_CTRL, 32'hFFFF_FFFE);
        quiet(4, "R10 no start");
        rd(A_CTRL, v); chk(v == 0, "R10 ctrl", v, 0);

        // R2 / R4 manual run
        wr(A_CTRL, 1);
        chk(layer_clr == 1'b1, "R2 clr rise", int'(layer_clr), 1);
        rd(A_CTRL, v); chk(v == 3, "R2 ctrl busy", v, 3);
        run_len("R3 manual length", n);
        rd(A_CTRL, v); chk(v == 0, "R4 retired", v, 0);

        // R5 rewrite during run is ignored
        wr(A_CTRL, 1);
        n = 0;
        while (layer_clr && n < 64) begin
            n++;
            reg_wr = (n == 3); reg_addr = A_CTRL; reg_wdata = 1;
            @(negedge clk);
        end
        reg_wr = 1'b0;
        chk(n == N, "R5 length unchanged", n, N);
        @(negedge clk);
        chk(!reinit_busy, "R5 no restart", int'(reinit_busy), 0);
        quiet(3, "R5 no late run");

        // R6 / R7 / R8 sweep: side, mask, error bit
        for (int side = 0; side < 2; side++) begin
            for (int m = 0; m < 8; m++) begin
                for (int b = 0; b < 3; b++) begin
                    wr(A_TXS, 7); wr(A_RXS, 7);
                    wr(A_TXE, side == 0 ? m : 0);
                    wr(A_RXE, side == 1 ? m : 0);
                    if (side == 0) tx_err_evt = 3'(1 << b); else rx_err_evt = 3'(1 << b);
                    @(negedge clk);
                    tx_err_evt = '0; rx_err_evt = '0;
                    rd(side == 0 ? A_TXS : A_RXS, v);
                    chk(v == (1 << b), "R6 latched", v, 1 << b);
                    @(negedge clk);
                    chk(layer_clr == m[b], "R7 masked trigger", int'(layer_clr), int'(m[b]));
                    if (m[b]) begin
                        rd(A_CTRL, v); chk(v == 2, "R8 auto ctrl", v, 2);
                        run_len("R3 auto length", n);
                        quiet(3, "R8 no retrigger");
                        rd(side == 0 ? A_TXE : A_RXE, v);
                        chk(v == m, "R11 mask kept", v, m);
                        rd(side == 0 ? A_TXS : A_RXS, v);
                        chk(v == (1 << b), "R11 status kept", v, 1 << b);
                    end else begin
                        quiet(2, "R7 masked quiet");
                    end
                end
            end
        end

        // R6 event beats same-cycle clear
        wr(A_TXE, 0); wr(A_TXS, 7); wr(A_RXE, 0); wr(A_RXS, 7);
        for (int b = 0; b < 3; b++) begin
            tx_err_evt = 3'(1 << b);
            wr(A_TXS, 7);
            tx_err_evt = '0;
            rd(A_TXS, v); chk(v == (1 << b), "R6 event wins", v, 1 << b);
            wr(A_TXS, 7);
            rd(A_TXS, v); chk(v == 0, "R6 w1c", v, 0);
        end

        // R9 manual and automatic on the same edge
        wr(A_RXE, 4);
        rx_err_evt = 3'b100;
        @(negedge clk);
        rx_err_evt = '0;
        wr(A_CTRL, 1);
        chk(layer_clr == 1'b1, "R9 start", int'(layer_clr), 1);
        rd(A_CTRL, v); chk(v == 3, "R9 ctrl", v, 3);
        run_len("R9 single length", n);
        rd(A_CTRL, v); chk(v == 0, "R9 bit cleared", v, 0);
        quiet(6, "R9 no second run");

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule